// File: doc/BRIEF.md
# Bidirectional GPIO Bank with Per-Channel Interrupts

This block gives software a 32-bit register window onto a bank of up to 28 bidirectional digital channels. A bus master reaches it through an AXI4-Lite-style slave port. Each channel can be an input or an output. Outputs drive a value set by software. Inputs pass through a two-flop synchroniser. Reading the data register returns, per channel, the driven value for an output or the synchronised pin value for an input.

Every channel can raise an event. In level mode the event fires while the synchronised input equals that channel's polarity bit. In change mode it fires on any transition between two consecutive synchronised samples. An event is recorded only for a channel whose enable bit is set. Recorded events sit in a status register until software writes a 1 to clear them. A single interrupt line comes from the OR of the status bits, gated by a global enable bit. The same OR also appears as a read-only pending flag.

Register words are selected by address bits 4:2: 0x00 global (bit 0 enable, bit 1 pending), 0x04 location, 0x08 data, 0x0C direction, 0x10 channel enable, 0x14 mode, 0x18 polarity, 0x1C status.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every channel is an input (gpioOe all zero). The data output, direction, channel enable, mode, polarity, status and global registers all read as zero, and irq is low.
- R2: Reading 0x08 returns the driven value for each channel whose direction bit is 1 and the synchronised pin value for each channel whose direction bit is 0. Bits 31:28 of every channel register always read as zero.
- R3: A direction bit of 1 makes the channel an output: gpioOe follows the direction register (0x0C) and gpioOut follows the value last written to 0x08.
- R4: A write changes only the byte lanes whose wstrb bit is 1 (wstrb[n] covers data bits 8n+7:8n). All other bytes keep their value.
- R5: The location register (0x04) reads the slotId input in bits 7:3 and zero in all other bits.
- R6: A channel in level mode (mode bit 0 at 0x14) sets its status bit while its synchronised input equals its polarity bit (0x18). Polarity 0 means low, polarity 1 means high.
- R7: A channel in change mode (mode bit 1) sets its status bit on either a rising or a falling transition of its synchronised input. A steady level does not set it, even right after a clear.
- R8: Status bits set only for channels whose enable bit at 0x10 is 1. A disabled channel's status stays 0 whatever its input does.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A level-mode bit whose condition is still present sets again at once, so it still reads 1.
- R10: irq equals global bit 0 ANDed with the OR of all status bits. Global bit 1 reads as the OR of all status bits, whatever the enable bit is.
- R11: Once raised, bvalid stays high until bready. Once raised, rvalid stays high with rdata stable until rready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| awaddr | input | 5 | Write byte address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response accepted by master |
| araddr | input | 5 | Read byte address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | 32 | Read data |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data accepted by master |
| slotId | input | 5 | Static slot-location value |
| gpioIn | input | 28 | Channel pin inputs (asynchronous) |
| gpioOut | output | 28 | Channel drive values |
| gpioOe | output | 28 | Channel output enables |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the master presents the write address and write data in the same cycle and holds both until they are accepted. They also assume that slotId stays constant outside reset. The bench drives every write as a joined address-and-data beat, keeps bready high, and sets slotId once before reset is released. Pin changes are applied away from clock edges, and the bench waits several cycles before any read that depends on them, so the synchroniser latency never decides an expected value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W  = 32;
  localparam int STRB_W = BUS_W / 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_GLOBAL = 3'd0,
    SEL_LOC    = 3'd1,
    SEL_DATA   = 3'd2,
    SEL_DIR    = 3'd3,
    SEL_IEN    = 3'd4,
    SEL_MODE   = 3'd5,
    SEL_POL    = 3'd6,
    SEL_STAT   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic              wrEn;
    regSel_e           wrSel;
    logic [BUS_W-1:0]  wrData;
    logic [STRB_W-1:0] wrStrb;
    regSel_e           rdSel;
  } busStrobe_t;

  function automatic logic [BUS_W-1:0] laneMerge(
    input logic [BUS_W-1:0]  oldVal,
    input logic [BUS_W-1:0]  newVal,
    input logic [STRB_W-1:0] strb
  );
    logic [BUS_W-1:0] res;
    res = oldVal;
    for (int b = 0; b < STRB_W; b++) begin
      if (strb[b]) res[b*8 +: 8] = newVal[b*8 +: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [BUS_W-1:0]  rdata,
  output logic              rvalid,
  input  logic              rready,
  input  logic [BUS_W-1:0]  rdMux,
  output busStrobe_t        strobe
);
  logic wrFire;
  logic rdFire;
  wire  unusedAddr = &{1'b0, awaddr[1:0], araddr[1:0]};

  assign wrFire  = awvalid && wvalid && !bvalid;
  assign awready = wrFire;
  assign wready  = wrFire;
  assign arready = !rvalid;
  assign rdFire  = arvalid && !rvalid;

  always_comb begin
    strobe.wrEn   = wrFire;
    strobe.wrSel  = regSel_e'(awaddr[4:2]);
    strobe.wrData = wdata;
    strobe.wrStrb = wstrb;
    strobe.rdSel  = regSel_e'(araddr[4:2]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wrFire) bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;
      if (rdFire) begin
        rvalid <= 1'b1;
        rdata  <= rdMux;
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end

  p_bresp_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    bvalid && !bready |=> bvalid);
  p_rdata_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int NCH    = 28,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [SLOT_W-1:0] slotId,
  input  logic [NCH-1:0]    gpioIn,
  output logic [NCH-1:0]    gpioOut,
  output logic [NCH-1:0]    gpioOe,
  output logic [BUS_W-1:0]  rdMux,
  output logic              irq
);
  localparam int PAD_W = BUS_W - NCH;

  logic [NCH-1:0] metaQ, syncQ, prevQ;
  logic [NCH-1:0] outReg, dirReg, ienReg, modeReg, polReg, statReg;
  logic           gEn;
  logic [NCH-1:0] hitVec, eventVec, clrMask, dataView;
  logic           pending;

  function automatic logic [NCH-1:0] wrMerge(input logic [NCH-1:0] cur, input busStrobe_t s);
    logic [BUS_W-1:0] full;
    full = laneMerge({{PAD_W{1'b0}}, cur}, s.wrData, s.wrStrb);
    return full[NCH-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= '0;
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      metaQ <= gpioIn;
      syncQ <= metaQ;
      prevQ <= syncQ;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_comb begin
      if (modeReg[c]) hitVec[c] = syncQ[c] ^ prevQ[c];
      else            hitVec[c] = ~(syncQ[c] ^ polReg[c]);
    end
  end

  assign eventVec = hitVec & ienReg;
  assign clrMask  = (strobe.wrEn && strobe.wrSel == SEL_STAT) ? wrMerge('0, strobe) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      dirReg  <= '0;
      ienReg  <= '0;
      modeReg <= '0;
      polReg  <= '0;
      statReg <= '0;
      gEn     <= 1'b0;
    end else begin
      statReg <= (statReg & ~clrMask) | eventVec;
      if (strobe.wrEn) begin
        unique case (strobe.wrSel)
          SEL_GLOBAL: if (strobe.wrStrb[0]) gEn <= strobe.wrData[0];
          SEL_DATA:   outReg  <= wrMerge(outReg, strobe);
          SEL_DIR:    dirReg  <= wrMerge(dirReg, strobe);
          SEL_IEN:    ienReg  <= wrMerge(ienReg, strobe);
          SEL_MODE:   modeReg <= wrMerge(modeReg, strobe);
          SEL_POL:    polReg  <= wrMerge(polReg, strobe);
          default: ;
        endcase
      end
    end
  end

  assign pending  = |statReg;
  assign irq      = gEn & pending;
  assign gpioOut  = outReg;
  assign gpioOe   = dirReg;
  assign dataView = (dirReg & outReg) | (~dirReg & syncQ);

  always_comb begin
    unique case (strobe.rdSel)
      SEL_GLOBAL: rdMux = {{(BUS_W-2){1'b0}}, pending, gEn};
      SEL_LOC:    rdMux = {{(BUS_W-SLOT_W-3){1'b0}}, slotId, 3'b000};
      SEL_DATA:   rdMux = {{PAD_W{1'b0}}, dataView};
      SEL_DIR:    rdMux = {{PAD_W{1'b0}}, dirReg};
      SEL_IEN:    rdMux = {{PAD_W{1'b0}}, ienReg};
      SEL_MODE:   rdMux = {{PAD_W{1'b0}}, modeReg};
      SEL_POL:    rdMux = {{PAD_W{1'b0}}, polReg};
      default:    rdMux = {{PAD_W{1'b0}}, statReg};
    endcase
  end

  // A status bit may only rise for a channel that was enabled
  p_rise_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statReg & ~$past(statReg) & ~$past(ienReg)) == '0));
  // Change-mode rise needs a transition in the previous sample pair
  p_change_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statReg & ~$past(statReg) & $past(modeReg) & ~$past(syncQ ^ prevQ)) == '0));
  // Level-mode rise needs input equal to polarity
  p_level_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statReg & ~$past(statReg) & ~$past(modeReg) & $past(syncQ ^ polReg)) == '0));
  // A status bit only falls after a write to the status word
  p_fall_by_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((~statReg & $past(statReg)) != '0) |-> $past(strobe.wrEn && strobe.wrSel == SEL_STAT));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int NCH    = 28,
  parameter int ADDR_W = 5,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              rready,
  input  logic [SLOT_W-1:0] slotId,
  input  logic [NCH-1:0]    gpioIn,
  output logic [NCH-1:0]    gpioOut,
  output logic [NCH-1:0]    gpioOe,
  output logic              irq
);
  busStrobe_t      strobe;
  logic [BUS_W-1:0] rdMux;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rvalid(rvalid), .rready(rready),
    .rdMux(rdMux), .strobe(strobe)
  );

  gpio_bank_datapath #(.NCH(NCH), .SLOT_W(SLOT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotId(slotId),
    .gpioIn(gpioIn), .gpioOut(gpioOut), .gpioOe(gpioOe),
    .rdMux(rdMux), .irq(irq)
  );
endmodule

// File: tb/gpio_bank_irq_tb_top.sv
module gpio_bank_irq_tb_top;
  localparam logic [4:0] A_GLB = 5'h00, A_LOC = 5'h04, A_DAT = 5'h08, A_DIR = 5'h0C,
                         A_IEN = 5'h10, A_MOD = 5'h14, A_POL = 5'h18, A_STA = 5'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1, arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid, irq;
  logic [31:0] rdata;
  logic [4:0]  slotId = 5'h15;
  logic [27:0] gpioIn = 28'hFFFFFFF;
  logic [27:0] gpioOut, gpioOe;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_bank_irq dut_i (
    .clk(clk), .rstN(rstN),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rvalid(rvalid), .rready(rready),
    .slotId(slotId), .gpioIn(gpioIn), .gpioOut(gpioOut), .gpioOe(gpioOe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d, input int hold = 0);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    d = rdata;
    for (int i = 0; i < hold; i++) begin
      check("R11 rvalid held", {31'd0, rvalid}, 32'd1);
      check("R11 rdata stable", rdata, d);
      @(negedge clk);
    end
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic clearAll();
    busWrite(A_IEN, 32'h0);
    busWrite(A_STA, 32'hFFFFFFFF);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 gpioOe", {4'd0, gpioOe}, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    busRead(A_GLB, v); check("R1 global", v, 32'h0);
    busRead(A_DIR, v); check("R1 dir", v, 32'h0);
    busRead(A_IEN, v); check("R1 enable", v, 32'h0);
    busRead(A_MOD, v); check("R1 mode", v, 32'h0);
    busRead(A_POL, v); check("R1 polarity", v, 32'h0);
    busRead(A_STA, v); check("R1 status", v, 32'h0);
    check("R1 gpioOut", {4'd0, gpioOut}, 32'h0);
  endtask

  task automatic testLocation();
    logic [31:0] v;
    busRead(A_LOC, v); check("R5 location", v, 32'h000000A8);
  endtask

  task automatic testDataDir();
    logic [31:0] v;
    busWrite(A_DIR, 32'h00000FFF);
    busWrite(A_DAT, 32'hFFFFF5A5);
    gpioIn = 28'h1234567;
    settle();
    check("R3 gpioOe", {4'd0, gpioOe}, 32'h00000FFF);
    check("R3 gpioOut", {4'd0, gpioOut}, 32'h0FFFF5A5);
    busRead(A_DAT, v); check("R2 data mix", v, 32'h012345A5);
    busRead(A_DIR, v); check("R2 dir upper zero", v, 32'h00000FFF);
    busWrite(A_DIR, 32'hFFFFFFFF);
    busRead(A_DAT, v); check("R2 all outputs", v, 32'h0FFFF5A5);
    busWrite(A_DIR, 32'h0);
    check("R3 back to inputs", {4'd0, gpioOe}, 32'h0);
    gpioIn = 28'hFFFFFFF;
    settle();
  endtask

  task automatic testStrobes();
    logic [31:0] v;
    busWrite(A_POL, 32'hFFFFFFFF, 4'b0101);
    busRead(A_POL, v); check("R4 lanes 0 and 2", v, 32'h00FF00FF);
    busWrite(A_POL, 32'h12345678, 4'b1000);
    busRead(A_POL, v); check("R4 lane 3 only", v, 32'h02FF00FF);
    busWrite(A_POL, 32'h0);
  endtask

  task automatic testLevel();
    logic [31:0] v;
    busWrite(A_GLB, 32'h1);
    busWrite(A_MOD, 32'h0);
    busWrite(A_IEN, 32'h1);
    settle();
    busRead(A_STA, v); check("R6 high input no event", v, 32'h0);
    gpioIn[0] = 1'b0;
    settle();
    busRead(A_STA, v); check("R6 low level sets", v, 32'h1);
    check("R10 irq raised", {31'd0, irq}, 32'h1);
    busRead(A_GLB, v); check("R10 pending and enable", v, 32'h3);
    busWrite(A_STA, 32'h1);
    busRead(A_STA, v); check("R9 level still present re-sets", v, 32'h1);
    gpioIn[0] = 1'b1;
    settle();
    busWrite(A_STA, 32'h1);
    busRead(A_STA, v); check("R9 cleared", v, 32'h0);
    check("R10 irq dropped", {31'd0, irq}, 32'h0);
    busWrite(A_POL, 32'h2);
    busWrite(A_IEN, 32'h2);
    settle();
    busRead(A_STA, v); check("R6 high polarity sets", v, 32'h2);
    clearAll();
    busWrite(A_POL, 32'h0);
    busRead(A_STA, v); check("R9 clear all", v, 32'h0);
  endtask

  task automatic testDisabled();
    logic [31:0] v;
    busWrite(A_IEN, 32'h0);
    gpioIn[2] = 1'b0; settle();
    gpioIn[2] = 1'b1; settle();
    busRead(A_STA, v); check("R8 disabled channel", v, 32'h0);
    check("R8 irq quiet", {31'd0, irq}, 32'h0);
  endtask

  task automatic testChange();
    logic [31:0] v;
    busWrite(A_MOD, 32'h8);
    busWrite(A_IEN, 32'h8);
    busWrite(A_STA, 32'hFFFFFFFF);
    settle();
    busRead(A_STA, v); check("R7 steady no event", v, 32'h0);
    gpioIn[3] = 1'b0; settle();
    busRead(A_STA, v); check("R7 falling edge sets", v, 32'h8);
    busWrite(A_STA, 32'h8);
    settle();
    busRead(A_STA, v); check("R7 held low stays clear", v, 32'h0);
    gpioIn[3] = 1'b1; settle();
    busRead(A_STA, v); check("R7 rising edge sets", v, 32'h8);
    busWrite(A_STA, 32'h0);
    busRead(A_STA, v); check("R9 write zero keeps", v, 32'h8);
    busWrite(A_GLB, 32'h0);
    check("R10 irq gated off", {31'd0, irq}, 32'h0);
    busRead(A_GLB, v); check("R10 pending while disabled", v, 32'h2);
    busWrite(A_GLB, 32'h1);
    check("R10 irq regated", {31'd0, irq}, 32'h1);
    clearAll();
    busWrite(A_MOD, 32'h0);
  endtask

  task automatic testHold();
    logic [31:0] v;
    busWrite(A_DIR, 32'h00A5A5A5);
    busRead(A_DIR, v, 3); check("R11 held read value", v, 32'h00A5A5A5);
    busWrite(A_DIR, 32'h0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLocation();
    testDataDir();
    testStrobes();
    testLevel();
    testDisabled();
    testChange();
    testHold();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule